// File: doc/BRIEF.md
# IR carrier burst generator

This block drives a single pin with a square-wave infrared carrier. It emits the carrier in bursts that always begin with a high half and end after a complete low half. Four standard carrier frequencies are available. A numerically controlled phase accumulator runs from the fixed system clock and produces the carrier. The accumulator keeps its fractional remainder from one half-period to the next. Single half-periods may therefore differ by one system clock, but the total length of an N-cycle burst tracks N divided by the carrier frequency and does not drift.

A burst is started in one of two ways. In count mode, a one-clock start pulse loads a cycle count; the block then produces exactly that many cycles and flags completion. In gate mode, a level input (typically the serial data line) turns the carrier on and off; when the level drops, the cycle already in progress is completed first. The frequency choice is captured when a burst starts and held until the burst ends.

Top module: `irc_carrier_gen`

## Requirements
- R1: While reset (`rstN` low) is asserted, and on the first sample after it, `carrier`, `busy` and `done` are low; reset also clears the phase accumulator, so the first burst after reset has the same timing as any other burst.
- R2: A `start` pulse while idle with a nonzero `burstLen` raises `busy` and drives `carrier` high on the same clock edge. The block then produces exactly `burstLen` full cycles, each a high half followed by a low half.
- R3: Measured from the rise of `busy` to its fall, a burst of N cycles at carrier frequency f lasts N·Fclk/f system clocks, with a difference of less than two clocks. This holds for long bursts (30 cycles at 38 kHz lasts about 39474 clocks at 50 MHz).
- R4: When a burst ends, `carrier` is low, `busy` falls, and `done` is high for exactly one clock, on the same edge where `busy` falls. `done` is low at every other time.
- R5: `freqSel` encoding: 0 selects 36 kHz, 1 selects 38 kHz, 2 selects 40 kHz, 3 selects 56 kHz. Every half-period is within one system clock of Fclk/(2f), and `carrier` changes only on an accumulator overflow.
- R6: A `start` pulse while `busy` is high is ignored: the burst in progress keeps its length, and no further burst follows it.
- R7: `freqSel` is captured at the start of a burst. A change of `freqSel` during the burst has no effect on that burst.
- R8: A `start` pulse with `burstLen` equal to 0 is ignored: `busy` stays low and `carrier` stays low.
- R9: Gate mode: when `gate` is high while idle, a burst starts. The burst ends when a low half completes while `gate` is low, so a gate drop in the high half or in the low half lets the current cycle finish. While idle with `gate` low, `carrier` stays low.
- R10: If `start` (with nonzero `burstLen`) and `gate` are both high in the same idle cycle, count mode is chosen. The burst then lasts `burstLen` cycles regardless of `gate`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (50 MHz nominal) |
| rstN | input | 1 | Asynchronous active-low reset |
| freqSel | input | 2 | Carrier frequency choice, captured at burst start |
| gate | input | 1 | Level that enables gate-mode bursts |
| start | input | 1 | One-clock pulse that launches a count-mode burst |
| burstLen | input | 6 | Number of carrier cycles for a count-mode burst |
| busy | output | 1 | High for the whole burst |
| done | output | 1 | One-clock pulse at the end of a burst |
| carrier | output | 1 | Carrier output, low when idle |

## Verification
The two launch paths can fire in the same idle cycle: a `start` pulse with a cycle count, and a high `gate` level. The bench raises both on one edge. It keeps `gate` high only through part of the first high half, which would give a single gate-mode cycle. The burst passes only if it runs the full commanded count and ends with a single `done` pulse. It must also show no gate-mode burst behind it.

// File: rtl/irc_pkg.sv
package irc_pkg;

  localparam int unsigned NUM_CARRIERS = 4;

  // Carrier table indexed by the frequency select code.
  localparam int unsigned CARRIER_HZ [NUM_CARRIERS] = '{36000, 38000, 40000, 56000};

  // Strobes from the burst control to the phase datapath.
  typedef struct packed {
    logic startBurst;  // clear accumulator, capture frequency choice
    logic run;         // advance accumulator this clock
  } dpCtrl_t;

  // Phase increment for an overflow rate of twice the carrier frequency.
  function automatic longint unsigned calcInc(longint unsigned carrierHz,
                                              longint unsigned clkHz,
                                              int unsigned accW);
    longint unsigned num;
    num = (2 * carrierHz) << accW;
    return (num + clkHz / 2) / clkHz;
  endfunction

endpackage

// File: rtl/irc_phase_dp.sv
module irc_phase_dp
  import irc_pkg::*;
#(
  parameter int unsigned CLK_HZ = 50_000_000,
  parameter int unsigned ACC_W  = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] freqSel,
  input  dpCtrl_t    dpCtrl,
  output logic       tick,
  output logic [1:0] selLatched
);

  logic [ACC_W-1:0] incTbl [NUM_CARRIERS];
  logic [ACC_W-1:0] acc;
  logic [ACC_W:0]   sum;

  for (genvar g = 0; g < NUM_CARRIERS; g++) begin : g_inc
    assign incTbl[g] = ACC_W'(calcInc(longint'(CARRIER_HZ[g]), longint'(CLK_HZ), ACC_W));
  end

  assign sum  = {1'b0, acc} + {1'b0, incTbl[selLatched]};
  assign tick = dpCtrl.run & sum[ACC_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc        <= '0;
      selLatched <= '0;
    end else if (dpCtrl.startBurst) begin
      acc        <= '0;
      selLatched <= freqSel;
    end else if (dpCtrl.run) begin
      acc <= sum[ACC_W-1:0];
    end
  end

endmodule

// File: rtl/irc_burst_ctrl.sv
module irc_burst_ctrl
  import irc_pkg::*;
#(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [CNT_W-1:0] burstLen,
  input  logic             gate,
  input  logic             tick,
  output dpCtrl_t          dpCtrl,
  output logic             carrier,
  output logic             busy,
  output logic             done
);

  logic             gateMode;
  logic [CNT_W-1:0] cyclesLeft;
  logic             launchCount;
  logic             launchGate;
  logic             lastCycle;

  assign launchCount = !busy && startReq && (burstLen != '0);
  assign launchGate  = !busy && !launchCount && gate;
  assign lastCycle   = gateMode ? !gate : (cyclesLeft == CNT_W'(1));

  assign dpCtrl.startBurst = launchCount | launchGate;
  assign dpCtrl.run        = busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      carrier    <= 1'b0;
      busy       <= 1'b0;
      done       <= 1'b0;
      gateMode   <= 1'b0;
      cyclesLeft <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (launchCount) begin
          busy       <= 1'b1;
          carrier    <= 1'b1;
          gateMode   <= 1'b0;
          cyclesLeft <= burstLen;
        end else if (launchGate) begin
          busy       <= 1'b1;
          carrier    <= 1'b1;
          gateMode   <= 1'b1;
          cyclesLeft <= '0;
        end
      end else if (tick) begin
        if (carrier) begin
          carrier <= 1'b0;
        end else if (lastCycle) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          carrier    <= 1'b1;
          cyclesLeft <= cyclesLeft - CNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/irc_carrier_gen.sv
module irc_carrier_gen
  import irc_pkg::*;
#(
  parameter int unsigned CLK_HZ = 50_000_000,
  parameter int unsigned ACC_W  = 32,
  parameter int unsigned CNT_W  = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       freqSel,
  input  logic             gate,
  input  logic             start,
  input  logic [CNT_W-1:0] burstLen,
  output logic             busy,
  output logic             done,
  output logic             carrier
);

  dpCtrl_t    dpCtrl;
  logic       tick;
  logic [1:0] selLatched;

  irc_phase_dp #(.CLK_HZ(CLK_HZ), .ACC_W(ACC_W)) phase_i (
    .clk        (clk),
    .rstN       (rstN),
    .freqSel    (freqSel),
    .dpCtrl     (dpCtrl),
    .tick       (tick),
    .selLatched (selLatched)
  );

  irc_burst_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (start),
    .burstLen (burstLen),
    .gate     (gate),
    .tick     (tick),
    .dpCtrl   (dpCtrl),
    .carrier  (carrier),
    .busy     (busy),
    .done     (done)
  );

endmodule

// File: rtl/irc_carrier_chk.sv
module irc_carrier_chk (
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic       done,
  input logic       carrier,
  input logic       tick,
  input logic [1:0] selLatched
);

  // R1 / R9: idle output is low
  a_r9_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !carrier);

  // R2: a burst opens with a high half
  a_r2_starts_high: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> carrier);

  // R4: done only on the edge where busy falls
  a_r4_done_at_end: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(busy) && !busy));

  // R4: busy never falls without done
  a_r4_end_has_done: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R9: a burst ends only after a completed low half
  a_r9_end_on_low: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (!carrier && !$past(carrier)));

  // R5: inside a burst, the carrier moves only on an overflow
  a_r5_toggle_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busy) && busy && (carrier != $past(carrier))) |-> $past(tick));

  // R7: captured frequency choice holds for the whole burst
  a_r7_sel_stable: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busy) && busy) |-> $stable(selLatched));

endmodule

bind irc_carrier_gen irc_carrier_chk chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .busy       (busy),
  .done       (done),
  .carrier    (carrier),
  .tick       (tick),
  .selLatched (selLatched)
);

// File: tb/irc_carrier_gen_tb_top.sv
module irc_carrier_gen_tb_top;

  localparam real CLK_HZ_R = 50.0e6;

  typedef struct {
    int    cycles;
    int    freqHz;
    string tag;
  } expBurst_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] freqSel = 2'd0;
  logic       gate = 1'b0;
  logic       start = 1'b0;
  logic [5:0] burstLen = 6'd0;
  logic       busy, done, carrier;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;
  expBurst_t expQ[$];

  irc_carrier_gen dut_i (
    .clk(clk), .rstN(rstN), .freqSel(freqSel), .gate(gate), .start(start),
    .burstLen(burstLen), .busy(busy), .done(done), .carrier(carrier)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int freqOf(input logic [1:0] s);
    case (s)
      2'd0: return 36000;
      2'd1: return 38000;
      2'd2: return 40000;
      default: return 56000;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input real act, input real exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0.3f expected=%0.3f", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // ---------------- monitor / scoreboard ----------------
  bit        prevBusy = 1'b0;
  bit        prevCar = 1'b0;
  bit        inBurst = 1'b0;
  int        startT, lastEdge, rises;
  expBurst_t cur;

  always @(negedge clk) begin
    if (!rstN) begin
      inBurst = 1'b0;
    end else begin
      if (busy && !prevBusy) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R6", "unexpected burst", 1.0, 0.0);
        end else begin
          cur = expQ.pop_front();
        end
        inBurst  = 1'b1;
        startT   = cyc;
        lastEdge = cyc;
        rises    = 1;
        check(carrier == 1'b1, "R2", {cur.tag, " carrier high at burst start"}, real'(carrier), 1.0);
      end else if (inBurst && busy && (carrier != prevCar)) begin
        check((cyc - lastEdge) >= CLK_HZ_R / (2.0 * cur.freqHz) - 1.0 &&
              (cyc - lastEdge) <= CLK_HZ_R / (2.0 * cur.freqHz) + 1.0,
              "R5", {cur.tag, " half period"}, real'(cyc - lastEdge),
              CLK_HZ_R / (2.0 * cur.freqHz));
        lastEdge = cyc;
        if (carrier) rises++;
      end else if (inBurst && !busy && prevBusy) begin
        check((cyc - lastEdge) >= CLK_HZ_R / (2.0 * cur.freqHz) - 1.0 &&
              (cyc - lastEdge) <= CLK_HZ_R / (2.0 * cur.freqHz) + 1.0,
              "R5", {cur.tag, " last half period"}, real'(cyc - lastEdge),
              CLK_HZ_R / (2.0 * cur.freqHz));
        check(rises == cur.cycles, "R2", {cur.tag, " cycle count"}, real'(rises), real'(cur.cycles));
        check((cyc - startT) > cur.cycles * CLK_HZ_R / cur.freqHz - 2.0 &&
              (cyc - startT) < cur.cycles * CLK_HZ_R / cur.freqHz + 2.0,
              "R3", {cur.tag, " burst duration"}, real'(cyc - startT),
              cur.cycles * CLK_HZ_R / cur.freqHz);
        check(done == 1'b1, "R4", {cur.tag, " done at end"}, real'(done), 1.0);
        check(carrier == 1'b0, "R4", {cur.tag, " carrier low at end"}, real'(carrier), 0.0);
        inBurst = 1'b0;
      end else if (done) begin
        check(1'b0, "R4", "done outside burst end", 1.0, 0.0);
      end
    end
    prevBusy = busy;
    prevCar  = carrier;
  end

  // ---------------- driver ----------------
  task automatic waitDone();
    do @(negedge clk); while (!done);
  endtask

  task automatic launchCount(input logic [1:0] s, input int n, input string tag);
    @(negedge clk);
    freqSel  = s;
    burstLen = 6'(n);
    start    = 1'b1;
    if (n != 0) expQ.push_back('{n, freqOf(s), tag});
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic runGate(input logic [1:0] s, input int k, input bit dropInHigh,
                         input string tag);
    int seen = 0;
    bit pc = 1'b0;
    @(negedge clk);
    freqSel = s;
    gate    = 1'b1;
    expQ.push_back('{k, freqOf(s), tag});
    while (seen < k) begin
      @(negedge clk);
      if (carrier && !pc) seen++;
      pc = carrier;
    end
    if (dropInHigh) begin
      repeat (100) @(negedge clk);
    end else begin
      while (carrier) @(negedge clk);
      repeat (50) @(negedge clk);
    end
    gate = 1'b0;
    waitDone();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!carrier && !busy && !done, "R1", "outputs low in reset",
          real'({carrier, busy, done}), 0.0);
    rstN = 1'b1;
    @(negedge clk);
    check(!carrier && !busy && !done, "R1", "outputs low after reset",
          real'({carrier, busy, done}), 0.0);

    // R2 R3 R4 R5: short bursts at each carrier
    launchCount(2'd3, 3, "R2 3@56k"); waitDone();
    launchCount(2'd0, 5, "R5 5@36k"); waitDone();
    launchCount(2'd2, 5, "R5 5@40k"); waitDone();
    launchCount(2'd1, 1, "R2 1@38k"); waitDone();
    // R3: long burst, no drift
    launchCount(2'd1, 30, "R3 30@38k"); waitDone();

    // R6: start while busy is ignored
    launchCount(2'd2, 4, "R6 4@40k");
    repeat (300) @(negedge clk);
    burstLen = 6'd10; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone();
    repeat (100) @(negedge clk);
    check(!busy, "R6", "no burst after ignored start", real'(busy), 0.0);

    // R7: frequency change mid-burst has no effect
    launchCount(2'd0, 4, "R7 4@36k held");
    repeat (10) @(negedge clk);
    freqSel = 2'd3;
    waitDone();
    launchCount(2'd3, 2, "R7 2@56k next"); waitDone();

    // R8: zero count ignored
    launchCount(2'd1, 0, "R8");
    repeat (50) @(negedge clk);
    check(!busy && !carrier, "R8", "zero count ignored", real'({busy, carrier}), 0.0);

    // R9: gate mode, drop in high half and in low half
    runGate(2'd3, 2, 1'b1, "R9 gate drop high");
    runGate(2'd1, 3, 1'b0, "R9 gate drop low");
    repeat (20) @(negedge clk);
    check(!busy && !carrier, "R9", "idle low after gate burst", real'({busy, carrier}), 0.0);

    // R10: start and gate in the same idle cycle
    @(negedge clk);
    freqSel = 2'd3; burstLen = 6'd3; start = 1'b1; gate = 1'b1;
    expQ.push_back('{3, 56000, "R10 start+gate"});
    @(negedge clk);
    start = 1'b0;
    repeat (200) @(negedge clk);
    gate = 1'b0;
    waitDone();
    repeat (50) @(negedge clk);
    check(!busy, "R10", "no gate burst after count burst", real'(busy), 0.0);

    // R1: reset mid-burst, then a clean burst
    launchCount(2'd0, 5, "R1 aborted");
    repeat (1000) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(!carrier && !busy && !done, "R1", "reset aborts burst",
          real'({carrier, busy, done}), 0.0);
    rstN = 1'b1;
    launchCount(2'd2, 2, "R1 after reset"); waitDone();

    repeat (10) @(negedge clk);
    check(expQ.size() == 0, "R2", "all expected bursts seen", real'(expQ.size()), 0.0);
    finishRun();
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "R2", "watchdog expired", real'(cyc), 0.0);
    finishRun();
  end

endmodule